// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block gathers five interrupt sources into one sticky flag register and raises a single interrupt request line toward the processor. Two of the sources are single-cycle pulses from on-chip logic: a USB transfer-done event and a timer underflow. The other three come from pins. Two dedicated external pins each have a flag of their own. A group of port-3 pins shares one flag between them. Every pin is passed through a two-flop synchronizer. A flag for a pin is set only on a falling edge (1 followed by 0), and only while that pin is marked as an input.

Software reaches three 8-bit registers through a simple register bus. Reads are combinational and writes take effect on the clock edge. The enable register (address 0) chooses which flags may drive the request line. The flag register (address 1) is read-only and reports which sources have fired. The clear register (address 2) is write-one-to-clear for the flags. Flags are recorded whether or not their source is enabled. A source whose flag is already set therefore raises the request at once when it is enabled.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Flag and enable bit positions: bit 1 is USB transfer done, bit 2 is timer underflow, bit 3 is the port-3 group, bit 4 is external pin 0 and bit 5 is external pin 1. Bits 0, 6 and 7 always read 0 in every register and cannot be written.
- R2: `irq_o` is high in exactly the cycles where at least one flag bit and its enable bit are both 1. It follows a register write or a flag change with no extra cycle of delay.
- R3: A pulse on `usb_done` or `tmr_uflow` during a clock edge sets the matching flag at that edge. The flag stays set until it is cleared, whether or not the source is enabled.
- R4: A write of 1 to a bit at address 2 clears that flag. A write of 0 leaves the flag unchanged.
- R5: If an event and a clear of the same bit fall on the same edge, the flag stays set.
- R6: Writes to address 1 have no effect. Address 2 reads as zero. Reads of address 3 return zero.
- R7: A falling edge on an external pin sets its flag on the third rising clock edge after the pin changes. A single edge sets the flag once.
- R8: Rising edges never set a flag. Neither does a falling edge on a pin whose input-mode bit is 0.
- R9: A qualifying falling edge on any one port-3 pin sets flag bit 3.
- R10: After reset, the enable register and the flag register are 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| reg_sel | input | 1 | Register bus select |
| reg_wr | input | 1 | Write strobe, valid with reg_sel |
| reg_addr | input | 2 | Register address: 0 enable, 1 flags, 2 clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr while reg_sel is high, else 0 |
| usb_done | input | 1 | USB transfer-finished pulse |
| tmr_uflow | input | 1 | Timer underflow pulse |
| p3_pin | input | P3_W | Port-3 pin levels |
| p3_in_mode | input | P3_W | Per-pin input-mode qualifier for port 3 |
| ext0_pin | input | 1 | External pin 0 level |
| ext0_in_mode | input | 1 | Input-mode qualifier for external pin 0 |
| ext1_pin | input | 1 | External pin 1 level |
| ext1_in_mode | input | 1 | Input-mode qualifier for external pin 1 |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two actions can land on the same flag bit in the same cycle: a source event setting it and a software write clearing it. The bench applies an event pulse and a write of 1 to the matching bit of the clear register on the same clock edge. It then reads the flag register and checks that the bit stayed set and that the request line stayed high while the bit is enabled. The same sequence is also run with a clear mask of 0 and with a clear of a different bit, which separates the priority rule from the ordinary clear behaviour.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned SRC_N   = 5;
  localparam int unsigned SRC_LSB = 1;
  // source index inside the flag vector (bit position minus SRC_LSB)
  localparam int unsigned IDX_USB = 0;
  localparam int unsigned IDX_TMR = 1;
  localparam int unsigned IDX_P3  = 2;
  localparam int unsigned IDX_X0  = 3;
  localparam int unsigned IDX_X1  = 4;

  typedef enum logic [1:0] {
    ADDR_EN  = 2'd0,
    ADDR_FLG = 2'd1,
    ADDR_CLR = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/irqc_fall_detect.sv
module irqc_fall_detect #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] mode_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;
  logic [W-1:0] s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = pin_i;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fall_o[i] = prev_q[i] & ~s2_q[i] & mode_i[i];
  end

  // R7: a single falling edge produces a one-cycle detect pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d, kill;

  always_comb begin
    kill   = clr_we_i ? clr_mask_i : '0;
    flag_d = (flag_q & ~kill) | evt_i;   // event wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R3: every event leaves its flag set on the next cycle
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  // R4: flags only drop on a clear write
  a_r4_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R5: same-cycle event and clear keeps the bit
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && ((evt_i & clr_mask_i) != '0))
      |=> ((flag_q & $past(evt_i & clr_mask_i)) == $past(evt_i & clr_mask_i)));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned P3_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             usb_done,
  input  logic             tmr_uflow,
  input  logic [P3_W-1:0]  p3_pin,
  input  logic [P3_W-1:0]  p3_in_mode,
  input  logic             ext0_pin,
  input  logic             ext0_in_mode,
  input  logic             ext1_pin,
  input  logic             ext1_in_mode,
  output logic             irq_o
);
  logic [P3_W-1:0] p3_fall;
  logic [1:0]      ext_fall;
  src_vec_t        evt, flags, en_q, en_d, wsrc;
  logic            wr_any, en_we, clr_we;

  irqc_fall_detect #(.W(P3_W)) u_p3_det (
    .clk(clk), .rst_n(rst_n), .pin_i(p3_pin), .mode_i(p3_in_mode), .fall_o(p3_fall));

  irqc_fall_detect #(.W(2)) u_ext_det (
    .clk(clk), .rst_n(rst_n),
    .pin_i({ext1_pin, ext0_pin}), .mode_i({ext1_in_mode, ext0_in_mode}),
    .fall_o(ext_fall));

  always_comb begin
    evt          = '0;
    evt[IDX_USB] = usb_done;
    evt[IDX_TMR] = tmr_uflow;
    evt[IDX_P3]  = |p3_fall;
    evt[IDX_X0]  = ext_fall[0];
    evt[IDX_X1]  = ext_fall[1];
  end

  always_comb begin
    wr_any = reg_sel & reg_wr;
    en_we  = wr_any & (reg_addr == ADDR_EN);
    clr_we = wr_any & (reg_addr == ADDR_CLR);
    wsrc   = reg_wdata[SRC_LSB +: SRC_N];
    en_d   = en_we ? wsrc : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  irqc_flag_bank #(.N(SRC_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .clr_we_i(clr_we), .clr_mask_i(wsrc), .flag_o(flags));

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      unique case (reg_addr_e'(reg_addr))
        ADDR_EN:  reg_rdata[SRC_LSB +: SRC_N] = en_q;
        ADDR_FLG: reg_rdata[SRC_LSB +: SRC_N] = flags;
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign irq_o = |(flags & en_q);

  // R2: with nothing enabled the request line stays low
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
  // R1: unused bit positions never read as 1
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] == 1'b0) && (reg_rdata[REG_W-1:SRC_LSB+SRC_N] == '0));
endmodule

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/100ps
module test_irq_flag_ctrl;
  localparam int P3W = 8;
  localparam int NV  = 12;
  // {wr, addr[1:0], wdata[7:0], usb, tmr, exp_flags[7:0], exp_irq}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h02, 1'b0}, // R3 usb sets, disabled
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h06, 1'b0}, // R3 timer sets
    {1'b1, 2'd0, 8'h02, 1'b0, 1'b0, 8'h06, 1'b1}, // R2 enable late -> irq now
    {1'b1, 2'd2, 8'h02, 1'b0, 1'b0, 8'h04, 1'b0}, // R4 clear usb
    {1'b1, 2'd2, 8'h00, 1'b1, 1'b0, 8'h06, 1'b1}, // R4 zero mask no effect
    {1'b1, 2'd2, 8'h02, 1'b1, 1'b0, 8'h06, 1'b1}, // R5 event wins
    {1'b1, 2'd2, 8'h04, 1'b1, 1'b0, 8'h02, 1'b1}, // R5 other bit clears
    {1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 8'h02, 1'b1}, // R6 write to flags ignored
    {1'b1, 2'd0, 8'hFD, 1'b0, 1'b0, 8'h02, 1'b0}, // R2 usb masked off
    {1'b1, 2'd0, 8'hFF, 1'b0, 1'b1, 8'h06, 1'b1}, // R2 enable all
    {1'b1, 2'd2, 8'hFF, 1'b0, 1'b0, 8'h00, 1'b0}, // R4 clear all
    {1'b1, 2'd0, 8'h00, 1'b0, 1'b1, 8'h04, 1'b0}  // R3 disabled still latches
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic usb_done = 0, tmr_uflow = 0;
  logic [P3W-1:0] p3_pin = '1, p3_in_mode = '1;
  logic ext0_pin = 1, ext0_in_mode = 1, ext1_pin = 1, ext1_in_mode = 1;
  logic irq_o;
  int checks = 0, failures = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  irq_flag_ctrl #(.P3_W(P3W)) i_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .usb_done(usb_done), .tmr_uflow(tmr_uflow),
    .p3_pin(p3_pin), .p3_in_mode(p3_in_mode),
    .ext0_pin(ext0_pin), .ext0_in_mode(ext0_in_mode),
    .ext1_pin(ext1_pin), .ext1_in_mode(ext1_in_mode), .irq_o(irq_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    #0.5 d = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ticks(3);
    rd(2'd0, rv); chk("R10 enable reset", rv, 8'h00);
    rd(2'd1, rv); chk("R10 flags reset", rv, 8'h00);
    chk("R10 irq reset", {7'd0, irq_o}, 8'h00);
    @(negedge clk); rst_n = 1;
    ticks(2);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      reg_sel   = VEC[v][21];
      reg_wr    = VEC[v][21];
      reg_addr  = VEC[v][20:19];
      reg_wdata = VEC[v][18:11];
      usb_done  = VEC[v][10];
      tmr_uflow = VEC[v][9];
      @(posedge clk); #1;
      reg_sel = 0; reg_wr = 0; usb_done = 0; tmr_uflow = 0;
      rd(2'd1, rv);
      chk($sformatf("R1/R3/R4/R5 vector %0d flags", v), rv, VEC[v][8:1]);
      chk($sformatf("R2 vector %0d irq", v), {7'd0, irq_o}, {7'd0, VEC[v][0]});
    end

    // R1: unused bits not writable in enable
    wr(2'd0, 8'hFF);
    rd(2'd0, rv); chk("R1 enable readback masks bits 0,6,7", rv, 8'h3E);
    rd(2'd2, rv); chk("R6 clear address reads zero", rv, 8'h00);
    rd(2'd3, rv); chk("R6 address 3 reads zero", rv, 8'h00);
    wr(2'd2, 8'hFF);

    // R7: ext0 falling edge latency
    @(negedge clk); ext0_pin = 0;
    ticks(2); rd(2'd1, rv); chk("R7 ext0 not yet after 2 edges", rv, 8'h00);
    ticks(1); rd(2'd1, rv); chk("R7 ext0 set on third edge", rv, 8'h10);
    chk("R2 ext0 irq", {7'd0, irq_o}, 8'h01);
    wr(2'd2, 8'h10);
    ticks(4); rd(2'd1, rv); chk("R7 single edge sets once", rv, 8'h00);

    // R8: rising edge ignored
    @(negedge clk); ext0_pin = 1;
    ticks(5); rd(2'd1, rv); chk("R8 rising edge ignored", rv, 8'h00);

    // R8: mode off ignored on ext1
    @(negedge clk); ext1_in_mode = 0; ext1_pin = 0;
    ticks(5); rd(2'd1, rv); chk("R8 ext1 non-input ignored", rv, 8'h00);
    @(negedge clk); ext1_pin = 1;
    ticks(4);
    @(negedge clk); ext1_in_mode = 1; ext1_pin = 0;
    ticks(5); rd(2'd1, rv); chk("R1 ext1 on bit 5", rv, 8'h20);
    wr(2'd2, 8'h20);

    // R9: single port-3 pin
    @(negedge clk); p3_pin[5] = 0;
    ticks(5); rd(2'd1, rv); chk("R9 port-3 pin 5 sets bit 3", rv, 8'h08);
    wr(2'd2, 8'h08);
    @(negedge clk); p3_in_mode[2] = 0; p3_pin[2] = 0;
    ticks(5); rd(2'd1, rv); chk("R8 port-3 non-input pin ignored", rv, 8'h00);

    wr(2'd0, 8'h00);
    chk("R2 all disabled irq low", {7'd0, irq_o}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule